// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called A and B, and can move data across in either direction. Each direction has its own capture register with its own clock. A-to-B capture takes the A-bus value, and B-to-A capture takes the B-bus value. Each direction also has a source select. It drives the opposite bus either with the live value from the source bus or with the value held in that direction's register.

Two enables decide which buses the block drives. The B-side enable is active high and the A-side enable is active low. With these settings the buses can be isolated from each other, passed through live, captured for later, or driven with both stored words at the same time.

There are no tri-state pins. Each bus is modelled as an input vector, a data output vector and an output-enable bit, and the enclosing level resolves the wires. Only capture is clocked. Every output path is combinational from the selects, the enables, the registers and the bus inputs.

Top module: `dual_reg_xcvr`

## Requirements
- R1: `q_ab` loads `a_in` on every rising edge of `clk_ab`, and `q_ba` loads `b_in` on every rising edge of `clk_ba`. Each register keeps its value across edges of the other direction's clock.
- R2: Capture happens on every rising edge whatever the values of `sel_ab`, `sel_ba`, `en_b` and `en_a_n`.
- R3: `b_oe` follows `en_b` (1 = drive B). `a_oe` is the inverse of `en_a_n` (0 = drive A).
- R4: With `sel_ab` = 0, `b_out` equals `a_in`. With `sel_ab` = 1, `b_out` equals the A-to-B register.
- R5: With `sel_ba` = 0, `a_out` equals `b_in`. With `sel_ba` = 1, `a_out` equals the B-to-A register.
- R6: With `en_b` = 0 and `en_a_n` = 1, neither output enable is asserted, and both registers still capture.
- R7: With `en_b` = 1, `en_a_n` = 0 and both selects at 1, B is driven with the stored A word and A is driven with the stored B word at the same time.
- R8: With both enables active and both selects at 0, a value first driven onto A from outside remains on both buses after the outside driver lets go. Each driven output feeds its own bus input back.
- R9: While `rst_n` is 0, both registers are cleared to zero asynchronously, without waiting for a clock.
- R10: In live mode, a change on a bus input appears on the opposite data output with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous clear of both registers, active low |
| en_b | input | 1 | Drive enable for bus B, active high |
| en_a_n | input | 1 | Drive enable for bus A, active low |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored B |
| a_in | input | W | Value seen on bus A |
| b_in | input | W | Value seen on bus B |
| a_out | output | W | Data the block offers to bus A |
| a_oe | output | 1 | Block drives bus A |
| b_out | output | W | Data the block offers to bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
The assertions sample only at rising edges of the two capture clocks. They assume the bus inputs and controls are steady around those edges, and they skip the first edge after reset, because no capture has happened yet to compare with. The stimulus changes every input and opens the clock gates only while the base clock is low, so no capture clock ever glitches. The feedback case is run through a bench bus model that is settled in time steps, so no combinational loop exists between bench and design.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  // Turns a raw enable pin into "drive now", whatever its polarity.
  function automatic logic drive_on(input logic pin, input bit active_low);
    return active_low ? ~pin : pin;
  endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W        = 8,
  parameter bit RESET_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (RESET_EN) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_plain
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) q <= d;
    end
  endgenerate

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W          = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic         sel,
  input  logic         en_pin,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic         oe
);

  function automatic logic [W-1:0] choose(input src_e s,
                                          input logic [W-1:0] l,
                                          input logic [W-1:0] r);
    return (s == SRC_STORED) ? r : l;
  endfunction

  src_e src;
  assign src  = src_e'(sel);
  assign dout = choose(src, live, stored);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign oe = drive_on(en_pin, 1'b1);
    end else begin : g_high
      assign oe = drive_on(en_pin, 1'b0);
    end
  endgenerate

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int W        = 8,
  parameter bit RESET_EN = 1'b1
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         en_b,
  input  logic         en_a_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  // Register contents, named so that the bound checker can reach them.
  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;

  xcvr_capture #(.W(W), .RESET_EN(RESET_EN)) u_cap_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(q_ab)
  );

  xcvr_capture #(.W(W), .RESET_EN(RESET_EN)) u_cap_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(q_ba)
  );

  xcvr_path #(.W(W), .ACTIVE_LOW(1'b0)) u_to_b (
    .sel(sel_ab), .en_pin(en_b), .live(a_in), .stored(q_ab),
    .dout(b_out), .oe(b_oe)
  );

  xcvr_path #(.W(W), .ACTIVE_LOW(1'b1)) u_to_a (
    .sel(sel_ba), .en_pin(en_a_n), .live(b_in), .stored(q_ba),
    .dout(a_out), .oe(a_oe)
  );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic         en_b,
  input logic         en_a_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);

  // Set after the first edge following reset, so that $past has a meaning.
  logic seen_ab;
  logic seen_ba;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) seen_ab <= 1'b0;
    else        seen_ab <= 1'b1;
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n) seen_ba <= 1'b0;
    else        seen_ba <= 1'b1;
  end

  // R1 and R2: capture does not depend on the selects or the enables.
  p_cap_ab_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    seen_ab |-> q_ab == $past(a_in));

  p_cap_ba_r1: assert property (@(posedge clk_ba) disable iff (!rst_n)
    seen_ba |-> q_ba == $past(b_in));

  p_stored_b_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (seen_ab && sel_ab) |-> b_out == $past(a_in));

  p_stored_a_r5: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (seen_ba && sel_ba) |-> a_out == $past(b_in));

  p_isolate_r6: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!en_b && en_a_n) |-> (!a_oe && !b_oe));

  p_cross_r7: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (seen_ba && en_b && !en_a_n && sel_ab && sel_ba)
      |-> (a_oe && b_oe && a_out == $past(b_in) && b_out == q_ab));

endmodule

bind dual_reg_xcvr xcvr_chk #(.W(W)) u_xcvr_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .en_b(en_b), .en_a_n(en_a_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe), .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/test_dual_reg_xcvr.sv
`timescale 1ns/1ps
module test_dual_reg_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic g_ab = 1'b0, g_ba = 1'b0;
  logic rst_n = 1'b1;
  logic en_b = 1'b0, en_a_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic clk_ab, clk_ba;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #2.5 clk = ~clk;
  assign clk_ab = clk & g_ab;
  assign clk_ba = clk & g_ba;

  dual_reg_xcvr #(.W(W)) i_dual_reg_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .en_b(en_b), .en_a_n(en_a_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_drv), .b_in(b_drv), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] want_out(input logic s, input logic [W-1:0] l,
                                            input logic [W-1:0] r);
    if (s) return r;
    return l;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R3 b_oe", W'(b_oe), W'(en_b));
    check("R3 a_oe", W'(a_oe), W'(!en_a_n));
    check("R4 b_out", b_out, want_out(sel_ab, a_drv, m_ab));
    check("R5 a_out", a_out, want_out(sel_ba, b_drv, m_ba));
  endtask

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sab, input logic sba, input logic eb,
                      input logic ean, input logic gab, input logic gba);
    @(negedge clk);
    a_drv = a; b_drv = b; sel_ab = sab; sel_ba = sba;
    en_b = eb; en_a_n = ean; g_ab = gab; g_ba = gba;
    @(posedge clk);
    if (gab) m_ab = a;
    if (gba) m_ba = b;
    #1;
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  // Bus model for the feedback case: external driver wins, else block, else pulled low.
  logic [W-1:0] ext_a = '0;
  bit ext_a_on = 1'b0;
  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      a_drv = ext_a_on ? ext_a : (a_oe ? a_out : '0);
      b_drv = b_oe ? b_out : '0;
      #0.2;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2 rst_n = 1'b0;
    @(negedge clk);
    sel_ab = 1'b1; sel_ba = 1'b1; en_b = 1'b1; en_a_n = 1'b0;
    #1;
    check("R9 reset b_out", b_out, '0);
    check("R9 reset a_out", a_out, '0);
    @(negedge clk); rst_n = 1'b1;

    // R6 isolation with both registers still capturing (R2).
    step(8'h3C, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    // R7 cross drive of both stored words.
    step(8'h11, 8'h22, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 b_out stored A", b_out, 8'h3C);
    check("R7 a_out stored B", a_out, 8'hC3);
    // R1 independence: only the B-to-A clock pulses.
    step(8'h77, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R1 A reg kept", b_out, 8'h3C);
    check("R1 B reg loaded", a_out, 8'h5A);

    // R10 live path follows input without any clock.
    step(8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    a_drv = 8'hE7; b_drv = 8'h7E; #0.5;
    check("R10 live A to B", b_out, 8'hE7);
    check("R10 live B to A", a_out, 8'h7E);

    // R8 feedback hold.
    ext_a = 8'hA5; ext_a_on = 1'b1; settle();
    ext_a_on = 1'b0; settle();
    check("R8 A holds", a_drv, 8'hA5);
    check("R8 B holds", b_drv, 8'hA5);

    // Random mix of modes and captures.
    for (int i = 0; i < 400; i++) begin
      logic [5:0] c;
      c = 6'($urandom);
      step(W'($urandom), W'($urandom), c[0], c[1], c[2], c[3], c[4], c[5]);
    end

    // R9 reset in mid run clears loaded registers.
    step(8'hF0, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk); g_ab = 1'b0; g_ba = 1'b0; rst_n = 1'b0; #1;
    m_ab = '0; m_ba = '0;
    check("R9 mid-run b_out", b_out, '0);
    check("R9 mid-run a_out", a_out, '0);
    @(negedge clk); rst_n = 1'b1;
    step(8'h99, 8'h66, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R1 after reset", b_out, 8'h99);
    check("R9 B still clear", a_out, 8'h00);

    finish_run();
  end
endmodule